// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns bytes written by a processor into asynchronous serial frames on a single output line. It has two storage stages. The first is a holding register that the processor writes. The second is a frame shifter that drives the line. Whenever the shifter has nothing to send and the holding register is full, the byte moves across. The holding register is then free for the next write while the previous byte is still going out.

Two status flags report the two stages separately. `hold_empty` means the holding register can take a write. `shift_empty` means the shifter has no frame in progress. The bit rate comes from a transmit clock enable, `bit_en`. A static select input sets how many enables make up one bit time: 1, 16 or 64. When the processor refills the holding register before the current frame ends, the next frame starts directly after the stop bit, with no idle cycle between frames.

Top module: `dbuf_ser_tx`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `serial_out` is 1 and both `hold_empty` and `shift_empty` are 1. This holds even when reset arrives in the middle of a frame.
- R2: If `wr_stb` is high on a clock edge while `hold_empty` is 1, the byte on `wr_data` is captured and `hold_empty` reads 0 after that edge.
- R3: A write while `hold_empty` is 0 is ignored. The byte already held is kept and is the one sent next. The ignored byte is never transmitted.
- R4: On the first edge where the shifter is idle and the holding register is full, the byte moves into the shifter. After that edge, `hold_empty` is 1, `shift_empty` is 0 and `serial_out` is 0, which is the start bit.
- R5: A frame is one start bit of 0, then the 8 data bits with bit 0 first, then one stop bit of 1. The line is 1 whenever no frame is in progress.
- R6: Each bit lasts F pulses of `bit_en`. F is 1 when `fact_sel` is 2'b00, 16 when it is 2'b01, and 64 when it is 2'b10 or 2'b11.
- R7: Bit time advances only on cycles with `bit_en` high. While `bit_en` is low during a frame, `serial_out` holds its value and `shift_empty` stays 0.
- R8: If the holding register is filled before the stop bit ends, the next start bit begins on the same edge that ends the stop bit, and `shift_empty` never goes high between the two frames.
- R9: With `bit_en` high every cycle and a load on edge L, `shift_empty` returns to 1 after edge L+10F, provided the holding register is empty at that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_stb | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Byte to write |
| bit_en | input | 1 | Transmit clock enable, one pulse per bit-rate tick |
| fact_sel | input | 2 | Bit-rate factor select, static |
| serial_out | output | 1 | Serial line, idles high |
| hold_empty | output | 1 | Holding register can accept a byte |
| shift_empty | output | 1 | No frame in progress |

## Verification
A write strobe sampled on edge E shows as `hold_empty` low after E. If the shifter is idle, the transfer happens one edge later, at L = E+1. After L the line is low and `hold_empty` is high again. With `bit_en` high every cycle, bit b holds from edge L+bF to edge L+(b+1)F, and `shift_empty` rises after L+10F. The bench drives inputs and samples outputs on falling edges. It counts those edges from L and checks each bit at its middle, F/2 cycles into it, which keeps clear of both bit boundaries. For the stall case, `bit_en` stays low after the load and is raised only when the bench restarts this count, so the same arithmetic applies.

// File: rtl/dbst_pkg.sv
package dbst_pkg;
   typedef enum logic [1:0] {
      FACT_UNIT     = 2'b00,
      FACT_MID      = 2'b01,
      FACT_HIGH     = 2'b10,
      FACT_HIGH_ALT = 2'b11
   } fact_e;
endpackage

// File: rtl/dbst_hold.sv
module dbst_hold #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_stb,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              take,
   output logic [DATA_W-1:0] data_q,
   output logic              full_q
);
   always_ff @(posedge clk) begin
      if (rst) begin
         full_q <= 1'b0;
         data_q <= '0;
      end else if (take) begin
         full_q <= 1'b0;
      end else if (wr_stb && !full_q) begin
         data_q <= wr_data;
         full_q <= 1'b1;
      end
   end
endmodule

// File: rtl/dbst_bit_timer.sv
module dbst_bit_timer
   import dbst_pkg::*;
#(
   parameter int MID_FACTOR  = 16,
   parameter int HIGH_FACTOR = 64
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       run,
   input  logic       bit_en,
   input  logic [1:0] fact_sel,
   output logic       tick
);
   localparam int CNT_W = $clog2(HIGH_FACTOR);
   localparam logic [CNT_W-1:0] MID_LAST  = CNT_W'(MID_FACTOR - 1);
   localparam logic [CNT_W-1:0] HIGH_LAST = CNT_W'(HIGH_FACTOR - 1);

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] last_cnt;

   generate
      if (MID_FACTOR == HIGH_FACTOR) begin : g_one_limit
         always_comb last_cnt = (fact_e'(fact_sel) == FACT_UNIT) ? '0 : HIGH_LAST;
      end else begin : g_two_limits
         always_comb begin
            case (fact_e'(fact_sel))
               FACT_UNIT: last_cnt = '0;
               FACT_MID:  last_cnt = MID_LAST;
               default:   last_cnt = HIGH_LAST;
            endcase
         end
      end
   endgenerate

   assign tick = run && bit_en && (cnt == last_cnt);

   always_ff @(posedge clk) begin
      if (rst || !run) begin
         cnt <= '0;
      end else if (bit_en) begin
         cnt <= (cnt == last_cnt) ? '0 : cnt + 1'b1;
      end
   end
endmodule

// File: rtl/dbst_shifter.sv
module dbst_shifter #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [DATA_W-1:0] load_data,
   input  logic              tick,
   output logic              busy,
   output logic              last_bit,
   output logic              line
);
   localparam int FRAME_W = DATA_W + 2;
   localparam int LEFT_W  = $clog2(FRAME_W + 1);

   logic [FRAME_W-1:0] frame_in;
   logic [FRAME_W-1:0] sreg;
   logic [LEFT_W-1:0]  left;

   assign frame_in[0]         = 1'b0;
   assign frame_in[FRAME_W-1] = 1'b1;
   generate
      for (genvar i = 0; i < DATA_W; i++) begin : g_frame
         assign frame_in[i+1] = load_data[i];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         sreg <= '1;
         left <= '0;
      end else if (load) begin
         sreg <= frame_in;
         left <= LEFT_W'(FRAME_W);
      end else if (tick) begin
         sreg <= {1'b1, sreg[FRAME_W-1:1]};
         left <= left - 1'b1;
      end
   end

   assign busy     = (left != '0);
   assign last_bit = (left == LEFT_W'(1));
   assign line     = sreg[0];
endmodule

// File: rtl/dbuf_ser_tx.sv
module dbuf_ser_tx #(
   parameter int DATA_W      = 8,
   parameter int MID_FACTOR  = 16,
   parameter int HIGH_FACTOR = 64
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_stb,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              bit_en,
   input  logic [1:0]        fact_sel,
   output logic              serial_out,
   output logic              hold_empty,
   output logic              shift_empty
);
   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("dbuf_ser_tx: DATA_W must be at least 1");
      end
      if (MID_FACTOR < 2 || HIGH_FACTOR < MID_FACTOR) begin : g_bad_factor
         $error("dbuf_ser_tx: need 2 <= MID_FACTOR <= HIGH_FACTOR");
      end
   endgenerate

   logic [DATA_W-1:0] held;
   logic              held_full;
   logic              busy;
   logic              last_bit;
   logic              tick;
   logic              load;

   assign load = held_full && (!busy || (tick && last_bit));

   dbst_hold #(.DATA_W(DATA_W)) u_hold (
      .clk     (clk),
      .rst     (rst),
      .wr_stb  (wr_stb),
      .wr_data (wr_data),
      .take    (load),
      .data_q  (held),
      .full_q  (held_full)
   );

   dbst_bit_timer #(.MID_FACTOR(MID_FACTOR), .HIGH_FACTOR(HIGH_FACTOR)) u_timer (
      .clk      (clk),
      .rst      (rst),
      .run      (busy),
      .bit_en   (bit_en),
      .fact_sel (fact_sel),
      .tick     (tick)
   );

   dbst_shifter #(.DATA_W(DATA_W)) u_shift (
      .clk       (clk),
      .rst       (rst),
      .load      (load),
      .load_data (held),
      .tick      (tick),
      .busy      (busy),
      .last_bit  (last_bit),
      .line      (serial_out)
   );

   assign hold_empty  = !held_full;
   assign shift_empty = !busy;
endmodule

// File: rtl/dbuf_ser_tx_chk.sv
module dbuf_ser_tx_chk (
   input logic clk,
   input logic rst,
   input logic wr_stb,
   input logic bit_en,
   input logic serial_out,
   input logic hold_empty,
   input logic shift_empty
);
   assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (serial_out && hold_empty && shift_empty));

   assert_write_fills_R2: assert property (@(posedge clk) disable iff (rst)
      (hold_empty && wr_stb) |=> !hold_empty);

   assert_start_on_load_R4: assert property (@(posedge clk) disable iff (rst)
      (shift_empty && !hold_empty) |=> (!shift_empty && !serial_out && hold_empty));

   assert_hold_waits_R4: assert property (@(posedge clk) disable iff (rst)
      (!hold_empty && !shift_empty && !bit_en) |=> !hold_empty);

   assert_idle_high_R5: assert property (@(posedge clk) disable iff (rst)
      shift_empty |-> serial_out);

   assert_freeze_R7: assert property (@(posedge clk) disable iff (rst)
      (!shift_empty && !bit_en) |=> ($stable(serial_out) && !shift_empty));
endmodule

bind dbuf_ser_tx dbuf_ser_tx_chk u_chk (
   .clk         (clk),
   .rst         (rst),
   .wr_stb      (wr_stb),
   .bit_en      (bit_en),
   .serial_out  (serial_out),
   .hold_empty  (hold_empty),
   .shift_empty (shift_empty)
);

// File: tb/dbuf_ser_tx_tb.sv
module dbuf_ser_tx_tb;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       wr_stb = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       bit_en = 1'b1;
   logic [1:0] fact_sel = 2'b00;
   logic       serial_out;
   logic       hold_empty;
   logic       shift_empty;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   dbuf_ser_tx u_dut (
      .clk         (clk),
      .rst         (rst),
      .wr_stb      (wr_stb),
      .wr_data     (wr_data),
      .bit_en      (bit_en),
      .fact_sel    (fact_sel),
      .serial_out  (serial_out),
      .hold_empty  (hold_empty),
      .shift_empty (shift_empty)
   );

   task automatic chk(input string req, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   function automatic int factor_of(input logic [1:0] s);
      return (s == 2'b00) ? 1 : (s == 2'b01) ? 16 : 64;
   endfunction

   // Strobe one byte; leaves the bench at the falling edge before load edge L.
   task automatic write_byte(input logic [7:0] d);
      @(negedge clk);
      wr_stb  = 1'b1;
      wr_data = d;
      @(negedge clk);
      wr_stb = 1'b0;
      chk("R2 hold_empty after write", hold_empty, 0);
   endtask

   // Called at the falling edge before load edge L; iteration m is after edge L+m.
   task automatic watch_frame(input logic [7:0] d, input int wr_at, input logic [7:0] wd,
                              input int junk_at, input logic [7:0] jd, input bit raise_en);
      int f;
      f = factor_of(fact_sel);
      for (int m = 0; m < 10 * f; m++) begin
         int b;
         int exp_bit;
         @(negedge clk);
         if (m == 0 && raise_en) bit_en = 1'b1;
         b = m / f;
         exp_bit = (b == 0) ? 0 : (b == 9) ? 1 : int'(d[b-1]);
         if (m % f == f / 2) chk("R5/R6 line bit", serial_out, exp_bit);
         if (m == 0) begin
            chk("R4 hold_empty on load", hold_empty, 1);
            chk("R4 start bit on load", serial_out, 0);
         end
         if (m % f == 0) chk("R8 shift_empty in frame", shift_empty, 0);
         if (m == wr_at) begin wr_stb = 1'b1; wr_data = wd; end
         if (m == wr_at + 1) begin
            wr_stb = 1'b0;
            chk("R2 hold full after refill", hold_empty, 0);
         end
         if (m == junk_at) begin wr_stb = 1'b1; wr_data = jd; end
         if (m == junk_at + 1) wr_stb = 1'b0;
      end
   endtask

   task automatic expect_idle(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         chk("R9 shift_empty idle", shift_empty, 1);
         chk("R5 idle line high", serial_out, 1);
         if (k == 0) chk("R3 hold empty at idle", hold_empty, 1);
      end
   endtask

   task automatic one_frame(input logic [7:0] d);
      write_byte(d);
      watch_frame(d, -5, 8'h00, -5, 8'h00, 1'b0);
      expect_idle(2);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      logic [7:0] pats [6];
      pats = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80};

      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1 line in reset", serial_out, 1);
      chk("R1 hold_empty in reset", hold_empty, 1);
      chk("R1 shift_empty in reset", shift_empty, 1);
      rst = 1'b0;
      @(negedge clk);
      chk("R1 line after reset", serial_out, 1);
      chk("R1 flags after reset", {hold_empty, shift_empty}, 2'b11);

      // R5/R6: patterns across all three factors
      for (int s = 0; s < 3; s++) begin
         fact_sel = 2'(s);
         foreach (pats[i]) one_frame(pats[i]);
      end
      // R6: alternate high-factor code
      fact_sel = 2'b11;
      one_frame(8'h3C);

      // R5: exhaustive bytes at unit factor
      fact_sel = 2'b00;
      for (int v = 0; v < 256; v++) one_frame(8'(v));

      // R3/R8: refill right after load, then a write while full that must be dropped
      write_byte(8'hC3);
      watch_frame(8'hC3, 2, 8'h96, 4, 8'hE7, 1'b0);
      watch_frame(8'h96, -5, 8'h00, -5, 8'h00, 1'b0);
      expect_idle(15);

      // R8: refill during the stop bit at factor 16
      fact_sel = 2'b01;
      write_byte(8'h4D);
      watch_frame(8'h4D, 9 * 16 + 8, 8'hB2, -5, 8'h00, 1'b0);
      watch_frame(8'hB2, -5, 8'h00, -5, 8'h00, 1'b0);
      expect_idle(3);

      // R7: no enables after load, line frozen on start bit
      bit_en = 1'b0;
      write_byte(8'h69);
      for (int k = 0; k < 100; k++) begin
         @(negedge clk);
         if (k % 25 == 24) begin
            chk("R7 line frozen", serial_out, 0);
            chk("R7 shift_empty frozen", shift_empty, 0);
         end
      end
      watch_frame(8'h69, -5, 8'h00, -5, 8'h00, 1'b1);
      expect_idle(2);

      // R1: reset mid-frame with a byte held
      write_byte(8'h00);
      @(negedge clk);
      wr_stb = 1'b1; wr_data = 8'h11;
      repeat (20) @(negedge clk);
      wr_stb = 1'b0;
      rst = 1'b1;
      @(negedge clk);
      chk("R1 line on mid-frame reset", serial_out, 1);
      chk("R1 flags on mid-frame reset", {hold_empty, shift_empty}, 2'b11);
      rst = 1'b0;
      expect_idle(5);

      finish_run();
   end
endmodule